// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources in front of a primary vectored controller. Each source has an enable bit and a pass-through bit. Sources that are not passed through are gated by their enable bits and ORed into one cascade request. That request is meant for the highest-numbered input of the primary controller. A source whose pass-through bit is set skips the cascade and drives the primary controller input with the same number on its own direct line.

Software programs the block over a small word-addressed register port. Writes take effect on the clock edge, and read data is combinational from the address. The enable mask changes only through two write-one-to-act registers, one that sets bits and one that clears them, so read-modify-write sequences are never needed. There are no latches to acknowledge. A masked or deasserted source leaves the status view as soon as the mask or the level changes.

The register index is decoded by one `unique case` over a register enumeration. The names are REG_STAT, REG_RAW, REG_ENSET, REG_ENCLR and REG_PASS, and every other index is unmapped. No sequencing state exists beyond the two mask registers and the two output stages.

Top module: `sic_cascade`

## Requirements
- R1: While rst_n is low and after it is released, the enable mask and the pass-through mask are zero, and cascade_req and direct_req are zero.
- R2: A write to index 2 (REG_ENSET) sets every enable bit whose wdata bit is 1 and leaves the enable bits under wdata 0 unchanged. Reading index 2 returns the current enable mask.
- R3: A write to index 3 (REG_ENCLR) clears every enable bit whose wdata bit is 1 and leaves the others unchanged. Writing all ones masks every source.
- R4: Reading index 0 (REG_STAT) returns src_lvl AND enable mask, with source i in bit i. The value follows the source level and the mask with no extra delay.
- R5: Reading index 1 (REG_RAW) returns src_lvl unmasked.
- R6: Reading index 3 returns zero. Reading any index from 5 to 7 returns zero.
- R7: Index 4 (REG_PASS) is a plain read/write pass-through mask, with bit i belonging to source i.
- R8: cascade_req equals, one clock after the inputs, the OR over i of src_lvl[i] AND enable[i] AND NOT pass[i]. A passed-through source never reaches it, whatever its enable bit.
- R9: direct_req[i] equals, one clock after the inputs, src_lvl[i] AND pass[i]. It does not depend on the enable bit.
- R10: Writes to indices 0, 1 and 5 to 7 change neither mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_lvl | input | 32 | Level-sensitive interrupt sources |
| cascade_req | output | 1 | Combined request toward the primary controller |
| direct_req | output | 32 | Per-source requests routed straight through |

## Verification
A write lands at the clock edge where it is presented. Read data for any index is combinational, so it reflects the new mask half a cycle later. cascade_req and direct_req are each registered once, so their values at a falling edge come from the source levels and masks present just before the preceding rising edge. The bench model keeps that rule: at every rising edge it first computes the expected outputs from the pre-edge levels and masks, then applies the write, and it compares the outputs at the following falling edge.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int SIC_AW = 3;

    typedef enum logic [SIC_AW-1:0] {
        REG_STAT  = 3'd0,
        REG_RAW   = 3'd1,
        REG_ENSET = 3'd2,
        REG_ENCLR = 3'd3,
        REG_PASS  = 3'd4
    } sic_reg_e;

endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SIC_AW-1:0] addr,
    input  logic [NSRC-1:0]   wdata,
    input  logic [NSRC-1:0]   src,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   pass_q,
    output logic [NSRC-1:0]   rdata
);

    localparam logic [NSRC-1:0] ZERO = '0;

    logic [NSRC-1:0] en_d;
    logic [NSRC-1:0] pass_d;

    // next-state for both masks
    always_comb begin
        en_d   = en_q;
        pass_d = pass_q;
        if (wr) begin
            unique case (addr)
                REG_ENSET: en_d   = en_q | wdata;
                REG_ENCLR: en_d   = en_q & ~wdata;
                REG_PASS:  pass_d = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= ZERO;
            pass_q <= ZERO;
        end else begin
            en_q   <= en_d;
            pass_q <= pass_d;
        end
    end

    // read mux
    always_comb begin
        unique case (addr)
            REG_STAT:  rdata = src & en_q;
            REG_RAW:   rdata = src;
            REG_ENSET: rdata = en_q;
            REG_ENCLR: rdata = ZERO;
            REG_PASS:  rdata = pass_q;
            default:   rdata = ZERO;
        endcase
    end

endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pass,
    output logic            cascade_q,
    output logic [NSRC-1:0] direct_q
);

    logic [NSRC-1:0] merge_term;
    logic [NSRC-1:0] bypass_term;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        assign merge_term[i]  = src[i] & en[i] & ~pass[i];
        assign bypass_term[i] = src[i] & pass[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cascade_q <= 1'b0;
            direct_q  <= '0;
        end else begin
            cascade_q <= |merge_term;
            direct_q  <= bypass_term;
        end
    end

endmodule

// File: rtl/sic_cascade.sv
module sic_cascade
    import sic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SIC_AW-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    input  logic [NSRC-1:0]   src_lvl,
    output logic              cascade_req,
    output logic [NSRC-1:0]   direct_req
);

    logic [NSRC-1:0] en_mask;
    logic [NSRC-1:0] pass_mask;

    sic_regs #(.NSRC(NSRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .src    (src_lvl),
        .en_q   (en_mask),
        .pass_q (pass_mask),
        .rdata  (reg_rdata)
    );

    sic_route #(.NSRC(NSRC)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_lvl),
        .en        (en_mask),
        .pass      (pass_mask),
        .cascade_q (cascade_req),
        .direct_q  (direct_req)
    );

endmodule

// File: rtl/sic_cascade_chk.sv
module sic_cascade_chk
    import sic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [SIC_AW-1:0] reg_addr,
    input logic [NSRC-1:0]   reg_wdata,
    input logic [NSRC-1:0]   reg_rdata,
    input logic [NSRC-1:0]   src_lvl,
    input logic              cascade_req,
    input logic [NSRC-1:0]   direct_req,
    input logic [NSRC-1:0]   en_mask,
    input logic [NSRC-1:0]   pass_mask
);

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ENSET) |=> ((en_mask & $past(reg_wdata)) == $past(reg_wdata)));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ENCLR) |=> ((en_mask & $past(reg_wdata)) == '0));

    a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_ENCLR) |-> (reg_rdata == '0));

    a_r8_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_req == (|($past(src_lvl) & $past(en_mask) & ~$past(pass_mask))));

    a_r9_direct: assert property (@(posedge clk) disable iff (!rst_n)
        direct_req == ($past(src_lvl) & $past(pass_mask)));

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == REG_ENSET || reg_addr == REG_ENCLR)) |=> $stable(en_mask));

    a_r7_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == REG_PASS) |=> $stable(pass_mask));

endmodule

bind sic_cascade sic_cascade_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .src_lvl     (src_lvl),
    .cascade_req (cascade_req),
    .direct_req  (direct_req),
    .en_mask     (en_mask),
    .pass_mask   (pass_mask)
);

// File: tb/sic_cascade_test.sv
`timescale 1ns/1ps
module sic_cascade_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_lvl = '0;
    logic        cascade_req;
    logic [31:0] direct_req;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] m_en = '0;
    logic [31:0] m_pass = '0;
    logic        x_casc = 1'b0;
    logic [31:0] x_dir = '0;

    always #10 clk = ~clk;

    sic_cascade uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
        .cascade_req(cascade_req), .direct_req(direct_req)
    );

    function automatic logic [31:0] m_read(input logic [2:0] a, input logic [31:0] s);
        case (a)
            3'd0: return s & m_en;
            3'd1: return s;
            3'd2: return m_en;
            3'd4: return m_pass;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // one cycle: drive, model at the edge, compare at the falling edge
    task automatic step(input string tag, input logic wr, input logic [2:0] a,
                        input logic [31:0] wd, input logic [31:0] s);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; src_lvl = s;
        @(posedge clk);
        x_casc = |(s & m_en & ~m_pass);
        x_dir  = s & m_pass;
        if (wr) begin
            case (a)
                3'd2: m_en = m_en | wd;
                3'd3: m_en = m_en & ~wd;
                3'd4: m_pass = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check({tag, " rdata"}, reg_rdata, m_read(a, s));
        check("R8 cascade_req", {31'd0, cascade_req}, {31'd0, x_casc});
        check("R9 direct_req", direct_req, x_dir);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        src_lvl = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        reg_addr = 3'd2;
        #1 check("R1 enable after reset", reg_rdata, 32'd0);
        reg_addr = 3'd4;
        #1 check("R1 pass after reset", reg_rdata, 32'd0);
        check("R1 cascade in reset", {31'd0, cascade_req}, 32'd0);
        check("R1 direct in reset", direct_req, 32'd0);
        rst_n = 1'b1;
        step("R1", 1'b0, 3'd2, 32'd0, 32'hFFFF_FFFF);

        // R2: set bits, zeros no effect
        step("R2", 1'b1, 3'd2, 32'h0000_00F5, 32'h0);
        step("R2", 1'b1, 3'd2, 32'h0000_0000, 32'h0);
        step("R2", 1'b0, 3'd2, 32'h0, 32'h0000_0001);
        // R4 status, R5 raw, R8 cascade
        step("R4", 1'b0, 3'd0, 32'h0, 32'hFFFF_0F0F);
        step("R4", 1'b0, 3'd0, 32'h0, 32'h0000_000A);
        step("R5", 1'b0, 3'd1, 32'h0, 32'h1234_5678);
        step("R8", 1'b0, 3'd0, 32'h0, 32'h0000_0000);
        // R3 clear
        step("R3", 1'b1, 3'd3, 32'h0000_0005, 32'hFFFF_FFFF);
        step("R3", 1'b0, 3'd2, 32'h0, 32'hFFFF_FFFF);
        step("R3", 1'b1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step("R3", 1'b0, 3'd0, 32'h0, 32'hFFFF_FFFF);
        // R7 pass-through, R8 exclusion, R9 direct
        step("R7", 1'b1, 3'd4, 32'hFFE0_0000, 32'h0);
        step("R7", 1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0);
        step("R8", 1'b0, 3'd4, 32'h0, 32'h8000_0000);
        step("R8", 1'b0, 3'd0, 32'h0, 32'h8000_0000);
        step("R9", 1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0040_0001);
        step("R9", 1'b0, 3'd0, 32'h0, 32'h0040_0001);
        step("R9", 1'b0, 3'd0, 32'h0, 32'h0);
        // R10 writes elsewhere ignored, R6 reads of zero
        step("R10", 1'b1, 3'd2, 32'h0000_FFFF, 32'h0);
        step("R10", 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0);
        step("R10", 1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0);
        step("R10", 1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0);
        step("R10", 1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0);
        step("R10", 1'b0, 3'd2, 32'h0, 32'h0);
        step("R10", 1'b0, 3'd4, 32'h0, 32'h0);
        step("R6", 1'b0, 3'd3, 32'h0, 32'hFFFF_FFFF);
        step("R6", 1'b0, 3'd6, 32'h0, 32'hFFFF_FFFF);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            step("R4 mixed", 1'($urandom % 3 == 0), 3'($urandom % 8),
                 $urandom, $urandom & $urandom);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule